// File: doc/BRIEF.md
# Reloadable Down-Counter Timer

This block is a 32-bit down-counting timer on a single-cycle register port. Software programs a start value into the count register, picks one of four tick rates and sets the enable bit. From then on the counter steps down once per tick. When it reaches zero, the timer does one of two things. With auto-reload on, it refills itself from the reload register and keeps running. With auto-reload off, it parks at zero and drops its enable. Each time zero is reached, the timer latches a terminal-count flag and sends out a one-cycle interrupt pulse.

The port has three registers: mode (address 0), count (address 1) and reload (address 2). Writes take effect at the clock edge that ends the access cycle. Read data is combinational in the access cycle. Any access to the mode register, read or write, clears the terminal-count flag. Two same-cycle coincidences are defined. A write to the reload register during a reload transfer goes into the counter too. A read of the counter during a reload transfer returns the newly loaded value.

Top module: `dcount_timer`

## Requirements
- R1: After reset, the mode, count and reload registers all read 0, and the interrupt output is low.
- R2: The mode register holds the terminal-count flag in bit 0, enable in bit 1, auto-reload in bit 2 and the tick select in bits 5:4, and it reads back in that layout. The value written to bit 0 is ignored, so a write can never set the flag.
- R3: Tick select 00 ticks every clock, 01 every 4th, 10 every 8th and 11 every 16th clock. Suppose count N is loaded and the enable write is accepted at edge E0. The interrupt is then high right after edge E0 + max(N,1)·D, where D is the divisor.
- R4: With auto-reload off, reaching zero sets the flag, clears enable and holds the count at 0. The interrupt is high for exactly the one cycle after the zero-reaching tick.
- R5: A read or a write of the mode register clears the flag at the end of that cycle. This clear beats a terminal event in the same cycle, and the flag can be set again by a later terminal event.
- R6: A mode write that turns auto-reload on (bit 2 going 0→1) loads the count from the reload register at that edge, and decrementing starts only in the following cycle.
- R7: With auto-reload on, a tick that would bring the count to zero loads the reload value instead. It also sets the flag and pulses the interrupt, so a reload value of P gives one interrupt every P ticks.
- R8: A count read returns the value before that cycle's decrement. In a reload-transfer cycle it returns the newly loaded value.
- R9: A value written to the count register on a tick cycle becomes active and is decremented in that same cycle.
- R10: A reload-register write in a reload-transfer cycle is also copied into the count.
- R11: Every mode write restarts the tick divider, so the next tick comes D cycles after that write.
- R12: A mode write that clears enable in a terminal cycle still yields that cycle's interrupt pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access strobe for this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register select: 0 mode, 1 count, 2 reload |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle (0 when not reading) |
| irqPulse | output | 1 | One-cycle terminal-count interrupt |

## Verification
Two functions can coincide: the automatic reload transfer at the end of a period, and a software access to the count or reload register. The bench enables a period-3 timer and counts clock edges from the enable write. It lands a count read exactly in the transfer cycle and later a reload write in another transfer cycle. It judges the first by the read returning the reload value instead of the old count of 1. It judges the second by the following read returning the newly written value. A disabling mode write is also placed in a terminal cycle, and it must still produce the interrupt.

// File: rtl/dcount_timer_pkg.sv
package dcount_timer_pkg;

  localparam int MODE_ADDR   = 0;
  localparam int COUNT_ADDR  = 1;
  localparam int RELOAD_ADDR = 2;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic rdEn;       // read access this cycle
    logic countWr;    // software write of the count
    logic reloadWr;   // software write of the reload value
    logic armLoad;    // auto-reload just switched on: copy reload into count
    logic tickDec;    // ordinary decrement
    logic termReload; // zero reached, refill from reload
    logic termStop;   // zero reached, park at zero
  } tmr_strobe_t;

endpackage

// File: rtl/dcount_timer_ctrl.sv
module dcount_timer_ctrl
  import dcount_timer_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int MAX_DIV_LOG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        modeIn,    // {csel[1:0], reload, enable}
  input  logic [DATA_W-1:0] effCount,
  output tmr_strobe_t       strb,
  output logic [DATA_W-1:0] modeWord,
  output logic              irqPulse
);

  localparam int PRE_W    = MAX_DIV_LOG;
  localparam int SEL_CNT  = 4;

  logic             tcQ, enQ, rldQ;
  logic [1:0]       cselQ;
  logic [PRE_W-1:0] presc;
  logic [PRE_W-1:0] divLast;
  logic [PRE_W-1:0] divLastTab [SEL_CNT];

  logic modeAcc, modeWr, tick, terminal, armLoad;

  // terminal prescaler value per select code
  for (genvar s = 0; s < SEL_CNT; s++) begin : g_div
    if (s == 0) begin : g_every
      assign divLastTab[s] = '0;
    end else begin : g_scaled
      assign divLastTab[s] = PRE_W'((1 << (MAX_DIV_LOG - 3 + s)) - 1);
    end
  end

  assign divLast = divLastTab[cselQ];

  assign modeAcc = busSel && (busAddr == ADDR_W'(MODE_ADDR));
  assign modeWr  = modeAcc && busWr;
  assign armLoad = modeWr && modeIn[1] && !rldQ;

  assign tick     = enQ && (presc == divLast) && !armLoad;
  assign terminal = tick && (effCount <= DATA_W'(1));

  always_comb begin
    strb            = '0;
    strb.rdEn       = busSel && !busWr;
    strb.countWr    = busSel && busWr && (busAddr == ADDR_W'(COUNT_ADDR));
    strb.reloadWr   = busSel && busWr && (busAddr == ADDR_W'(RELOAD_ADDR));
    strb.armLoad    = armLoad;
    strb.tickDec    = tick && !terminal;
    strb.termReload = terminal && rldQ;
    strb.termStop   = terminal && !rldQ;
  end

  // tick divider: restarted by any mode write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
    end else if (modeWr || !enQ) begin
      presc <= '0;
    end else if (presc == divLast) begin
      presc <= '0;
    end else begin
      presc <= presc + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enQ   <= 1'b0;
      rldQ  <= 1'b0;
      cselQ <= 2'b00;
    end else if (modeWr) begin
      enQ   <= modeIn[0];
      rldQ  <= modeIn[1];
      cselQ <= modeIn[3:2];
    end else if (strb.termStop) begin
      enQ   <= 1'b0;
    end
  end

  // flag: access clears with priority over a same-cycle terminal event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcQ      <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= terminal;
      if (modeAcc) begin
        tcQ <= 1'b0;
      end else if (terminal) begin
        tcQ <= 1'b1;
      end
    end
  end

  assign modeWord = DATA_W'({cselQ, 1'b0, rldQ, enQ, tcQ});

endmodule

// File: rtl/dcount_timer_dp.sv
module dcount_timer_dp
  import dcount_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_strobe_t       strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] modeWord,
  output logic [DATA_W-1:0] effCount,
  output logic [DATA_W-1:0] countQ,
  output logic [DATA_W-1:0] busRdata
);

  logic [DATA_W-1:0] reloadQ;
  logic [DATA_W-1:0] loadValue;

  // a same-cycle count write is the value that gets decremented
  assign effCount  = strb.countWr  ? busWdata : countQ;
  // a same-cycle reload write feeds the transfer directly
  assign loadValue = strb.reloadWr ? busWdata : reloadQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reloadQ <= '0;
    end else if (strb.reloadWr) begin
      reloadQ <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countQ <= '0;
    end else if (strb.armLoad) begin
      countQ <= reloadQ;
    end else if (strb.termReload) begin
      countQ <= loadValue;
    end else if (strb.termStop) begin
      countQ <= '0;
    end else if (strb.tickDec) begin
      countQ <= effCount - DATA_W'(1);
    end else if (strb.countWr) begin
      countQ <= busWdata;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdEn) begin
      case (busAddr)
        ADDR_W'(MODE_ADDR):   busRdata = modeWord;
        ADDR_W'(COUNT_ADDR):  busRdata = strb.termReload ? loadValue : countQ;
        ADDR_W'(RELOAD_ADDR): busRdata = reloadQ;
        default:              busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
  import dcount_timer_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int MAX_DIV_LOG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqPulse
);

  tmr_strobe_t       strb;
  logic [DATA_W-1:0] modeWord;
  logic [DATA_W-1:0] effCount;
  logic [DATA_W-1:0] countQ;

  dcount_timer_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_DIV_LOG(MAX_DIV_LOG)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .modeIn   ({busWdata[5:4], busWdata[2:1]}),
    .effCount (effCount),
    .strb     (strb),
    .modeWord (modeWord),
    .irqPulse (irqPulse)
  );

  dcount_timer_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .modeWord (modeWord),
    .effCount (effCount),
    .countQ   (countQ),
    .busRdata (busRdata)
  );

endmodule

// File: rtl/dcount_timer_chk.sv
module dcount_timer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              irqPulse,
  input logic [2:0]        modeLow,
  input logic [DATA_W-1:0] countQ,
  input logic              termReload,
  input logic              reloadWr
);

  logic modeAccess, modeWrite;
  assign modeAccess = busSel && (busAddr == ADDR_W'(0));
  assign modeWrite  = modeAccess && busWr;

  // R5
  tc_clear_on_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modeAccess |=> !modeLow[0]);

  // R2
  tc_only_by_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modeLow[0]) |-> irqPulse);

  // R4
  stop_parks_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irqPulse && !$past(modeWrite) && !modeLow[2]) |-> (!modeLow[1] && countQ == '0));

  // R10
  reload_write_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (termReload && reloadWr) |=> (countQ == $past(busWdata)));

  // R12
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |-> $past(modeLow[1]));

endmodule

bind dcount_timer dcount_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busSel     (busSel),
  .busWr      (busWr),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .irqPulse   (irqPulse),
  .modeLow    (modeWord[2:0]),
  .countQ     (countQ),
  .termReload (strb.termReload),
  .reloadWr   (strb.reloadWr)
);

// File: tb/dcount_timer_tb.sv
module dcount_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = 32'd0;
  logic [31:0] busRdata;
  logic        irqPulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] rd;

  always #2 clk = ~clk;  // 250 MHz

  dcount_timer dut_i (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqPulse(irqPulse)
  );

  // table: start count, tick select
  localparam int NVEC = 6;
  localparam int VCNT [NVEC] = '{5, 3, 2, 2, 1, 0};
  localparam int VSEL [NVEC] = '{0, 1, 2, 3, 0, 1};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one bus cycle, entered and left 1 ns after a rising edge
  task automatic cyc(input logic sel, input logic wr, input logic [1:0] addr,
                     input logic [31:0] data);
    busSel = sel; busWr = wr; busAddr = addr; busWdata = data;
    #1 rd = busRdata;
    @(posedge clk);
    #1;
    busSel = 1'b0; busWr = 1'b0; busAddr = 2'd0; busWdata = 32'd0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d); cyc(1'b1, 1'b1, a, d); endtask
  task automatic rdr(input logic [1:0] a); cyc(1'b1, 1'b0, a, 32'd0); endtask
  task automatic idle(); cyc(1'b0, 1'b0, 2'd0, 32'd0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=expired expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'd0, irqPulse}, 32'd0);
    rdr(2'd0); chk("R1 mode", rd, 32'd0);
    rdr(2'd1); chk("R1 count", rd, 32'd0);
    rdr(2'd2); chk("R1 reload", rd, 32'd0);

    // R2 writing the flag position does nothing
    wr(2'd0, 32'h1);
    rdr(2'd0); chk("R2 tc write ignored", rd, 32'd0);

    // R3 / R4 table walk
    for (int v = 0; v < NVEC; v++) begin
      int div, lat, expLat;
      div = (VSEL[v] == 0) ? 1 : (1 << (VSEL[v] + 1));
      expLat = ((VCNT[v] < 1) ? 1 : VCNT[v]) * div;
      wr(2'd1, VCNT[v]);
      wr(2'd0, (VSEL[v] << 4) | 32'h2);
      lat = 0;
      for (int j = 1; j <= 100; j++) begin
        idle();
        if (irqPulse) begin lat = j; break; end
      end
      chk("R3 irq latency", lat, expLat);
      rdr(2'd1); chk("R4 count held at zero", rd, 32'd0);
      chk("R4 irq one cycle", {31'd0, irqPulse}, 32'd0);
      rdr(2'd0); chk("R2 R4 mode after stop", rd, (VSEL[v] << 4) | 32'h1);
      rdr(2'd0); chk("R5 flag cleared by read", rd, VSEL[v] << 4);
    end

    // R2 readback of all fields
    wr(2'd0, 32'h34);
    rdr(2'd0); chk("R2 readback", rd, 32'h34);
    wr(2'd0, 32'h0);

    // R6 / R7 / R8 / R10 auto-reload sequence
    wr(2'd2, 32'd3);
    wr(2'd0, 32'h4);                    // arm: count <- 3
    rdr(2'd1); chk("R6 arm load", rd, 32'd3);
    wr(2'd0, 32'h6);                    // enable at E0
    idle();                             // k1: 3->2
    chk("R6 no early irq", {31'd0, irqPulse}, 32'd0);
    rdr(2'd1); chk("R8 pre-decrement read", rd, 32'd2);   // k2
    rdr(2'd1); chk("R8 read in transfer", rd, 32'd3);     // k3 terminal
    chk("R7 irq at period end", {31'd0, irqPulse}, 32'd1);
    rdr(2'd0); chk("R7 flag set, running", rd, 32'h7);    // k4
    chk("R7 irq single cycle", {31'd0, irqPulse}, 32'd0);
    rdr(2'd0); chk("R5 flag cleared", rd, 32'h6);         // k5
    wr(2'd2, 32'd7);                                      // k6 terminal
    chk("R7 second period irq", {31'd0, irqPulse}, 32'd1);
    rdr(2'd1); chk("R10 reload write copied", rd, 32'd7); // k7
    rdr(2'd2); chk("R10 reload stored", rd, 32'd7);
    wr(2'd0, 32'h0);

    // R9 count write while running
    wr(2'd1, 32'd50);
    wr(2'd0, 32'h2);
    wr(2'd1, 32'd100);
    rdr(2'd1); chk("R9 written value decremented", rd, 32'd99);
    wr(2'd0, 32'h0);

    // R12 / R5 disable in terminal cycle
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h2);
    idle();
    wr(2'd0, 32'h0);
    chk("R12 irq after disable", {31'd0, irqPulse}, 32'd1);
    rdr(2'd0); chk("R5 access beats terminal", rd, 32'h0);
    rdr(2'd1); chk("R12 count zero", rd, 32'd0);

    // R11 divider restart on mode write
    wr(2'd1, 32'd100);
    wr(2'd0, 32'h32);
    repeat (4) idle();
    wr(2'd0, 32'h32);
    repeat (15) idle();
    rdr(2'd1); chk("R11 no tick before 16", rd, 32'd100);
    rdr(2'd1); chk("R11 tick at 16", rd, 32'd99);
    wr(2'd0, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule